// File: doc/BRIEF.md
# Programmable Serial Bit-Rate Tick Generator

This block produces the bit timing for a serial port that always acts as clock master. An 8-bit divisor X sets the reload value of a free-running down-counter. That counter emits one prescale pulse every X + 1 clocks. A post-divider turns the prescale pulses into a one-cycle bit tick. In asynchronous operation the post-divider divides by 64 when the speed select is low and by 16 when it is high. In synchronous operation it always divides by 4, whatever the speed select says. In asynchronous operation the block also emits a receive-sample tick at sixteen times the bit rate, so that a downstream receiver can vote on three samples near the middle of each bit.

Software or a parent controller writes the divisor through a one-cycle strobe. A write reloads the counter and clears the post-divider on the same edge, so the new period is measured from the write and the old period is never finished. A change of operating rate restarts the timing in the same way. A rate change means asynchronous slow, asynchronous fast or synchronous.

A small control state machine has two states. ST_HOLD is entered from reset and emits no pulses. The transition ST_HOLD to ST_RUN happens on the first clock after reset is released and counts as a restart. ST_RUN loops on itself. Inside ST_RUN, a divisor write or a rate change performs a restart without leaving the state.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is applied, both tick outputs stay 0 and the divisor returns to 0. The first clock edge with reset low restarts timing, so the first bit tick comes 64, 16 or 4 cycles after that edge, for asynchronous slow, asynchronous fast and synchronous operation.
- R2: With sync_mode = 0 and hi_speed = 0, bit ticks are 64 × (X + 1) clock cycles apart.
- R3: With sync_mode = 0 and hi_speed = 1, bit ticks are 16 × (X + 1) clock cycles apart.
- R4: With sync_mode = 1, bit ticks are 4 × (X + 1) cycles apart. Toggling hi_speed in this mode neither restarts nor alters the timing. X = 0 gives the fastest rate, one tick every 4 cycles.
- R5: A write (div_wr = 1 for one cycle) stores div_wdata as X and restarts timing at that clock edge. The first tick appears N × (X_new + 1) cycles after the write edge, where N is 64, 16 or 4. This holds even when the write lands in the middle of a period.
- R6: A change of sync_mode, or of hi_speed while asynchronous, restarts timing at the next edge. The first tick in the new rate appears N_new × (X + 1) cycles after that edge.
- R7: In asynchronous operation, sample_tick pulses 16 times per bit period. The first pulse comes (N / 16) × (X + 1) cycles after a restart, and the sixteenth pulse coincides with the bit tick. In synchronous operation sample_tick stays 0.
- R8: baud_tick is high for exactly one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| div_wr | input | 1 | One-cycle write strobe for the divisor |
| div_wdata | input | 8 | Divisor value X written on div_wr |
| sync_mode | input | 1 | 1 = synchronous master, 0 = asynchronous |
| hi_speed | input | 1 | Asynchronous speed select: 1 = divide by 16, 0 = divide by 64 |
| baud_tick | output | 1 | One-cycle pulse per bit period |
| sample_tick | output | 1 | Receive-sample pulse at 16 × bit rate, asynchronous only |

## Verification
The assertions assume that the mode inputs change only at a clock edge and that div_wr is a clean, single-cycle strobe. They also assume that reset is applied from time zero. The restart checks rely on no new bit tick being possible within four cycles of a restart. The bench keeps within these limits. It drives every input at the falling edge, always pulses div_wr for exactly one cycle, and holds reset for several cycles at the start. Random divisor values are bounded per rate so that every measured pair of periods fits the run length.

// File: rtl/baud_pkg.sv
package baud_pkg;

    typedef enum logic [1:0] {
        RATE_ASYNC_LO = 2'd0,
        RATE_ASYNC_HI = 2'd1,
        RATE_SYNC     = 2'd2
    } rate_e;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } gen_state_e;

    localparam int POST_LO   = 64;
    localparam int POST_HI   = 16;
    localparam int POST_SYNC = 4;
    localparam int POST_MAX  = POST_LO;
    localparam int POST_W    = $clog2(POST_MAX);
    localparam int OVERSAMP  = 16;

    function automatic rate_e rate_decode(input logic sync_sel, input logic fast_sel);
        if (sync_sel)
            return RATE_SYNC;
        else if (fast_sel)
            return RATE_ASYNC_HI;
        else
            return RATE_ASYNC_LO;
    endfunction

    function automatic int post_ratio(input rate_e r);
        case (r)
            RATE_ASYNC_LO: return POST_LO;
            RATE_ASYNC_HI: return POST_HI;
            default:       return POST_SYNC;
        endcase
    endfunction

endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
    import baud_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             sync_mode,
    input  logic             hi_speed,
    output logic             run,
    output logic             restart,
    output logic [DIV_W-1:0] reload_val,
    output logic [DIV_W-1:0] div_q,
    output rate_e            rate_q
);

    gen_state_e state_q, state_d;
    rate_e      rate_in;

    assign rate_in = rate_decode(sync_mode, hi_speed);

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_HOLD;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_HOLD;
        endcase
    end

    // outputs of the controller
    always_comb begin
        run        = 1'b0;
        restart    = 1'b0;
        reload_val = div_wr ? div_wdata : div_q;
        unique case (state_q)
            ST_HOLD: begin
                run     = 1'b0;
                restart = 1'b1;
            end
            ST_RUN: begin
                run     = 1'b1;
                restart = div_wr || (rate_in != rate_q);
            end
            default: begin
                run     = 1'b0;
                restart = 1'b1;
            end
        endcase
    end

    // divisor register
    always_ff @(posedge clk) begin
        if (rst)
            div_q <= '0;
        else if (div_wr)
            div_q <= div_wdata;
    end

    // registered operating rate, captured on every restart
    always_ff @(posedge clk) begin
        if (rst)
            rate_q <= RATE_ASYNC_LO;
        else if (restart)
            rate_q <= rate_in;
    end

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] reload_val,
    input  logic [DIV_W-1:0] div_q,
    output logic             pre_pulse,
    output logic [DIV_W-1:0] cnt_q
);

    logic at_zero;

    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= reload_val;
        else if (at_zero)
            cnt_q <= div_q;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    always_comb begin
        pre_pulse = run && at_zero;
    end

endmodule

// File: rtl/baud_postdiv.sv
module baud_postdiv
    import baud_pkg::*;
#(
    parameter int PW = POST_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          pre_pulse,
    input  rate_e         rate_q,
    output logic          baud_tick,
    output logic          sample_tick,
    output logic [PW-1:0] pdiv_q
);

    localparam logic [PW-1:0] LAST_LO   = PW'(POST_LO - 1);
    localparam logic [PW-1:0] LAST_HI   = PW'(POST_HI - 1);
    localparam logic [PW-1:0] LAST_SYNC = PW'(POST_SYNC - 1);
    localparam logic [PW-1:0] OVS_MASK  = PW'(POST_LO / OVERSAMP - 1);

    logic [PW-1:0] last;
    logic          wrap;

    always_comb begin
        unique case (rate_q)
            RATE_ASYNC_LO: last = LAST_LO;
            RATE_ASYNC_HI: last = LAST_HI;
            RATE_SYNC:     last = LAST_SYNC;
            default:       last = LAST_SYNC;
        endcase
    end

    assign wrap = pre_pulse && (pdiv_q == last);

    always_ff @(posedge clk) begin
        if (rst || restart)
            pdiv_q <= '0;
        else if (wrap)
            pdiv_q <= '0;
        else if (pre_pulse)
            pdiv_q <= pdiv_q + 1'b1;
    end

    // tick outputs
    always_comb begin
        baud_tick   = wrap;
        sample_tick = 1'b0;
        unique case (rate_q)
            RATE_ASYNC_LO: sample_tick = pre_pulse && ((pdiv_q & OVS_MASK) == OVS_MASK);
            RATE_ASYNC_HI: sample_tick = pre_pulse;
            RATE_SYNC:     sample_tick = 1'b0;
            default:       sample_tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             sync_mode,
    input  logic             hi_speed,
    output logic             baud_tick,
    output logic             sample_tick
);

    logic              run;
    logic              restart;
    logic [DIV_W-1:0]  reload_val;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  cnt_q;
    logic              pre_pulse;
    logic [POST_W-1:0] pdiv_q;
    rate_e             rate_q;

    baud_ctrl #(.DIV_W(DIV_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .div_wr     (div_wr),
        .div_wdata  (div_wdata),
        .sync_mode  (sync_mode),
        .hi_speed   (hi_speed),
        .run        (run),
        .restart    (restart),
        .reload_val (reload_val),
        .div_q      (div_q),
        .rate_q     (rate_q)
    );

    baud_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .restart    (restart),
        .reload_val (reload_val),
        .div_q      (div_q),
        .pre_pulse  (pre_pulse),
        .cnt_q      (cnt_q)
    );

    baud_postdiv #(.PW(POST_W)) u_post (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .pre_pulse   (pre_pulse),
        .rate_q      (rate_q),
        .baud_tick   (baud_tick),
        .sample_tick (sample_tick),
        .pdiv_q      (pdiv_q)
    );

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk
    import baud_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              div_wr,
    input logic              sync_mode,
    input logic              baud_tick,
    input logic              sample_tick,
    input logic              run,
    input logic [DIV_W-1:0]  cnt_q,
    input logic [DIV_W-1:0]  div_q,
    input logic [POST_W-1:0] pdiv_q,
    input rate_e             rate_q
);

    logic rst_d = 1'b0;

    always_ff @(posedge clk) rst_d <= rst;

    // R1: a cycle that follows a reset edge is silent
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst_d |-> (!baud_tick && !sample_tick));

    // R2: post-divider stays below the ratio of the active rate
    p_post_bound_r2: assert property (@(posedge clk) disable iff (rst)
        int'(pdiv_q) < post_ratio(rate_q));

    // R4: with sync held, the active rate is synchronous whatever the speed bit
    p_sync_speed_r4: assert property (@(posedge clk) disable iff (rst)
        (run && sync_mode && $past(sync_mode)) |-> (rate_q == RATE_SYNC));

    // R5: counter never runs above the stored divisor
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= div_q));

    // R5: a write restarts timing, so no tick right after it
    p_write_gap_r5: assert property (@(posedge clk) disable iff (rst)
        div_wr |=> !baud_tick);

    // R6: entering or leaving synchronous operation restarts timing
    p_enter_sync_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_mode) |=> !baud_tick);
    p_leave_sync_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_mode) |=> !baud_tick);

    // R7: no sample pulses once synchronous operation is settled
    p_sync_no_sample_r7: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && $past(sync_mode)) |-> !sample_tick);

    // R8: bit tick lasts one cycle
    p_tick_single_r8: assert property (@(posedge clk) disable iff (rst)
        baud_tick |=> !baud_tick);

endmodule

bind baud_tick_gen baud_tick_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .div_wr      (div_wr),
    .sync_mode   (sync_mode),
    .baud_tick   (baud_tick),
    .sample_tick (sample_tick),
    .run         (run),
    .cnt_q       (cnt_q),
    .div_q       (div_q),
    .pdiv_q      (pdiv_q),
    .rate_q      (rate_q)
);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       div_wr = 1'b0;
    logic [7:0] div_wdata = 8'd0;
    logic       sync_mode = 1'b0;
    logic       hi_speed = 1'b0;
    logic       baud_tick;
    logic       sample_tick;

    int n_checks = 0;
    int n_fail   = 0;
    int cur_x    = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    baud_tick_gen uut (
        .clk         (clk),
        .rst         (rst),
        .div_wr      (div_wr),
        .div_wdata   (div_wdata),
        .sync_mode   (sync_mode),
        .hi_speed    (hi_speed),
        .baud_tick   (baud_tick),
        .sample_tick (sample_tick)
    );

    function automatic int ratio_of(input bit sm, input bit hs);
        if (sm) return 4;
        return hs ? 16 : 64;
    endfunction

    function automatic string rate_req(input bit sm, input bit hs);
        if (sm) return "R4";
        return hs ? "R3" : "R2";
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // apply a restart cause at a falling edge, then time two bit ticks
    task automatic run_case(input bit wr, input int x, input bit sm, input bit hs,
                            input bit rel, input string tag);
        int first = -1;
        int second = -1;
        int scnt = 0;
        int sfirst = -1;
        int dbl = 0;
        bit prev = 1'b0;
        int exp;
        @(negedge clk);
        if (rel) rst = 1'b0;
        div_wr    = wr;
        div_wdata = 8'(x);
        sync_mode = sm;
        hi_speed  = hs;
        if (wr) cur_x = x;
        for (int k = 1; k <= 70000 && second < 0; k++) begin
            @(negedge clk);
            div_wr = 1'b0;
            if (first < 0 && sample_tick) begin
                scnt++;
                if (sfirst < 0) sfirst = k;
            end
            if (baud_tick && prev) dbl++;
            prev = baud_tick;
            if (baud_tick) begin
                if (first < 0) first = k;
                else second = k;
            end
        end
        exp = ratio_of(sm, hs) * (cur_x + 1);
        chk(first == exp, tag, first, exp);
        chk(second - first == exp, rate_req(sm, hs), second - first, exp);
        chk(dbl == 0, "R8", dbl, 0);
        if (sm) begin
            chk(scnt == 0, "R7", scnt, 0);
        end else begin
            chk(scnt == 16, "R7", scnt, 16);
            chk(sfirst == exp / 16, "R7", sfirst, exp / 16);
        end
    endtask

    initial begin
        int x;
        int k;
        bit sm;
        bit hs;
        void'($urandom(32'd5150));

        // R1: quiet during reset
        repeat (3) begin
            @(negedge clk);
            chk(!baud_tick && !sample_tick, "R1", {baud_tick, sample_tick}, 0);
        end
        // R1: release acts as a restart with divisor 0
        run_case(1'b0, 0, 1'b0, 1'b0, 1'b1, "R1");

        // R6: rate changes with X = 0, R4 fastest rate
        run_case(1'b0, 0, 1'b0, 1'b1, 1'b0, "R6");
        run_case(1'b0, 0, 1'b1, 1'b1, 1'b0, "R4");

        // random rates and divisors, R5 write restart
        for (int t = 0; t < 8; t++) begin
            sm = 1'($urandom % 2);
            hs = 1'($urandom % 2);
            if (!sm && !hs)      x = int'($urandom % 64);
            else if (!sm && hs)  x = int'($urandom % 128);
            else                 x = int'($urandom % 256);
            run_case(1'b1, x, sm, hs, 1'b0, "R5");
        end

        // R2: largest divisor, slow asynchronous
        run_case(1'b1, 255, 1'b0, 1'b0, 1'b0, "R2");

        // R5: write in the middle of a long period
        run_case(1'b1, 200, 1'b0, 1'b0, 1'b0, "R5");
        @(negedge clk);
        div_wr = 1'b1; div_wdata = 8'd200;
        @(negedge clk);
        div_wr = 1'b0;
        repeat (1000) @(negedge clk);
        run_case(1'b1, 3, 1'b0, 1'b0, 1'b0, "R5");

        // R6: rate change in the middle of a period
        run_case(1'b1, 20, 1'b0, 1'b1, 1'b0, "R5");
        repeat (100) @(negedge clk);
        run_case(1'b0, 0, 1'b0, 1'b0, 1'b0, "R6");

        // R4: speed bit ignored in synchronous operation
        run_case(1'b1, 10, 1'b1, 1'b0, 1'b0, "R4");
        hi_speed = 1'b1;
        k = 0;
        for (int j = 1; j <= 1000 && k == 0; j++) begin
            @(negedge clk);
            if (baud_tick) k = j;
        end
        chk(k == 44, "R4", k, 44);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule